// File: doc/BRIEF.md
# Prioritized UART Interrupt Status Unit

This block gathers the five interrupt causes of a UART-style peripheral and turns them into one interrupt line and one 8-bit status word. The causes are a line-status error, received data ready, a receive timeout, transmit holding register empty, and a modem status change. Each cause arrives as a one-cycle set pulse. The block holds it in a pending flag, but only while the enable for that cause is high. Software reads the status word to learn the most urgent pending cause. The word also carries two mode flags: whether the FIFOs are on, and whether they run in 64-byte or 16-byte depth.

The causes fall into four priority levels. A read strobe returns the current status word combinationally. On the next clock edge it clears only the cause that the word reported. Other pending causes stay latched and show up one at a time on later reads, highest level first.

Top module: `uart_isr_unit`

## Requirements
- R1: After a synchronous active-low reset, no cause is pending, `irq` is 0, and with `fifo_on` low the status word reads 8'h01.
- R2: Causes are ranked from most to least urgent as follows: line error (index 0), then the two receive causes (indexes 1 and 2), then transmit empty (index 3), then modem change (index 4). While a higher cause is pending, no lower cause is reported, but the lower cause stays latched.
- R3: Bits [3:1] of the word hold the code of the reported cause: line error 3'b011, data ready 3'b010, receive timeout 3'b110, transmit empty 3'b001, modem change 3'b000.
- R4: Bit 0 of the word is 0 while any enabled cause is pending and 1 when none is.
- R5: Bits [7:6] both equal `fifo_on`. Bit 5 equals `fifo_deep` (1 means 64-byte mode). Bit 4 is always 0.
- R6: A read strobe clears, on the following clock edge, only the cause reported in that cycle. A strobe with nothing pending changes nothing.
- R7: When data ready and receive timeout are both pending, data ready is reported first.
- R8: A set pulse on a cause whose enable bit is 0 is ignored. Dropping an enable bit hides that cause at once and discards its pending flag on the next edge.
- R9: `irq` is 1 exactly when some enabled cause is pending, which is the inverse of status bit 0.
- R10: If a set pulse for a cause arrives in the same cycle as the read that clears it, the set wins and the cause stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_set | input | 5 | One-cycle set pulses, indexed as in R2 |
| src_en | input | 5 | Per-cause enable bits, same indexing |
| fifo_on | input | 1 | FIFOs enabled flag |
| fifo_deep | input | 1 | 64-byte FIFO mode flag |
| rd_stb | input | 1 | Status register read strobe |
| status | output | 8 | Status word |
| irq | output | 1 | Active-high interrupt request |

## Verification
A set pulse is applied at one rising edge, and the resulting pending cause appears in `status` and `irq` during the next cycle. The mode flags and enable masking act combinationally in the same cycle they are driven. A read returns its word in the strobe cycle, and the clear shows in the cycle after. The bench drives every input just after a falling edge and samples one nanosecond later. Each expected word therefore belongs to a single cycle: it reflects the edges before that cycle and the inputs applied in it.

// File: rtl/uart_isr_pkg.sv
// Package: shared constants and the cause-to-code mapping of the
// interrupt status unit. Assumes five causes, ranked by index (0 highest).
package uart_isr_pkg;

    localparam int NUM_CAUSE = 5;
    localparam int CODE_W    = 3;
    localparam int WORD_W    = 8;
    localparam int IDX_W     = $clog2(NUM_CAUSE);

    localparam int C_LINE  = 0;
    localparam int C_RXRDY = 1;
    localparam int C_RXTMO = 2;
    localparam int C_TXEMP = 3;
    localparam int C_MODEM = 4;

    // Returns the status code for a cause index.
    function automatic logic [CODE_W-1:0] cause_code(input int idx);
        logic [CODE_W-1:0] c;
        case (idx)
            C_LINE:  c = 3'b011;
            C_RXRDY: c = 3'b010;
            C_RXTMO: c = 3'b110;
            C_TXEMP: c = 3'b001;
            default: c = 3'b000;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/isr_pend_bank.sv
// Pending-flag bank: one flag per cause. A flag is set by an enabled set
// pulse, cleared by its clear bit, and dropped when its enable is low.
// Set has precedence over clear. Assumes a synchronous active-low reset.
module isr_pend_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] en_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        logic flag_q;

        // Holds one cause's pending flag across cycles.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q <= 1'b0;
            else
                flag_q <= en_i[i] & (set_i[i] | (flag_q & ~clr_i[i]));
        end

        assign pend_o[i] = flag_q;
    end

endmodule

// File: rtl/isr_prio_pick.sv
// Priority picker: grants the lowest-indexed active request and reports
// whether any request is active. Assumes index 0 is most urgent.
module isr_prio_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o,
    output logic         any_o
);

    // Walks from the least urgent up so the most urgent request wins.
    always_comb begin
        grant_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
            end
        end
    end

    // Flags that at least one request is active.
    assign any_o = |req_i;

endmodule

// File: rtl/isr_word_fmt.sv
// Status word formatter: places the mode flags, the cause code and the
// active-low none-pending bit into the 8-bit status word.
// Assumes the code is already zero when nothing is pending.
module isr_word_fmt
    import uart_isr_pkg::*;
(
    input  logic              any_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              fifo_on_i,
    input  logic              fifo_deep_i,
    output logic [WORD_W-1:0] word_o
);

    // Assembles the status word field by field.
    always_comb begin
        word_o      = '0;
        word_o[7]   = fifo_on_i;
        word_o[6]   = fifo_on_i;
        word_o[5]   = fifo_deep_i;
        word_o[4]   = 1'b0;
        word_o[3:1] = code_i;
        word_o[0]   = ~any_i;
    end

endmodule

// File: rtl/uart_isr_unit.sv
// Top of the interrupt status unit. Latches cause pulses, masks them by
// their enables, picks the most urgent one, formats the status word and
// clears only the reported cause on a read strobe. Assumes rd_stb is a
// one-cycle strobe per read.
module uart_isr_unit
    import uart_isr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CAUSE-1:0] src_set,
    input  logic [NUM_CAUSE-1:0] src_en,
    input  logic                 fifo_on,
    input  logic                 fifo_deep,
    input  logic                 rd_stb,
    output logic [WORD_W-1:0]    status,
    output logic                 irq
);

    logic [NUM_CAUSE-1:0] pend_q;
    logic [NUM_CAUSE-1:0] active;
    logic [NUM_CAUSE-1:0] grant;
    logic [NUM_CAUSE-1:0] clr;
    logic                 any_act;
    logic [CODE_W-1:0]    code;

    isr_pend_bank #(.N(NUM_CAUSE)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (src_set),
        .en_i   (src_en),
        .clr_i  (clr),
        .pend_o (pend_q)
    );

    // Hides causes whose enable is low in the current cycle.
    assign active = pend_q & src_en;

    isr_prio_pick #(.N(NUM_CAUSE)) u_pick (
        .req_i   (active),
        .grant_o (grant),
        .any_o   (any_act)
    );

    // Maps the one-hot grant onto its cause code.
    always_comb begin
        code = '0;
        for (int i = 0; i < NUM_CAUSE; i++) begin
            if (grant[i])
                code = code | cause_code(i);
        end
    end

    // Clears only the reported cause, and only on a read.
    assign clr = rd_stb ? grant : '0;

    isr_word_fmt u_fmt (
        .any_i       (any_act),
        .code_i      (code),
        .fifo_on_i   (fifo_on),
        .fifo_deep_i (fifo_deep),
        .word_o      (status)
    );

    // Raises the interrupt line while any enabled cause is pending.
    assign irq = any_act;

endmodule

// File: rtl/uart_isr_chk.sv
// Checker for uart_isr_unit: temporal properties on the ports and on the
// pending flags. Attached to every instance of the top through bind.
module uart_isr_chk
    import uart_isr_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_CAUSE-1:0] src_set,
    input logic [NUM_CAUSE-1:0] src_en,
    input logic                 fifo_on,
    input logic                 fifo_deep,
    input logic                 rd_stb,
    input logic [WORD_W-1:0]    status,
    input logic                 irq,
    input logic [NUM_CAUSE-1:0] pend
);

    // R1: reset empties every pending flag
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (pend == '0));

    // R5: mode flags and the unused bit
    p_mode_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7:6] == {2{fifo_on}}) && (status[5] == fifo_deep) && !status[4]);

    // R9: interrupt line mirrors the pending bit of the word
    p_irq_matches_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ~status[0]);

    // R6: one read removes at most one pending cause
    p_clear_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> ($countones(pend) + 1 >= $countones($past(pend))));

    // R2: modem code shows only when no higher enabled cause is pending
    p_modem_lowest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[0] && status[3:1] == 3'b000) |-> ((pend[3:0] & src_en[3:0]) == '0));

    for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_cause
        // R10: an enabled set always leaves the cause pending
        p_set_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (src_set[i] && src_en[i]) |=> pend[i]);

        // R8: a disabled cause holds no flag after the edge
        p_disabled_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !src_en[i] |=> !pend[i]);
    end

endmodule

bind uart_isr_unit uart_isr_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_set   (src_set),
    .src_en    (src_en),
    .fifo_on   (fifo_on),
    .fifo_deep (fifo_deep),
    .rd_stb    (rd_stb),
    .status    (status),
    .irq       (irq),
    .pend      (pend_q)
);

// File: tb/tb_uart_isr_unit.sv
// Bench for uart_isr_unit: a vector table walked by one loop, followed by
// directed cases for set/clear collision, enables, empty reads and reset.
module tb_uart_isr_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] src_set = '0;
    logic [4:0] src_en = '0;
    logic       fifo_on = 1'b0;
    logic       fifo_deep = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] status;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    uart_isr_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_set   (src_set),
        .src_en    (src_en),
        .fifo_on   (fifo_on),
        .fifo_deep (fifo_deep),
        .rd_stb    (rd_stb),
        .status    (status),
        .irq       (irq)
    );

    // Vector: {set, en, fifo_on, fifo_deep, rd, expected status, expected irq}
    localparam int NV = 13;
    localparam logic [21:0] VEC [NV] = '{
        {5'b00000, 5'b11111, 1'b0, 1'b0, 1'b0, 8'h01, 1'b0}, // R1 idle
        {5'b10000, 5'b11111, 1'b0, 1'b0, 1'b0, 8'h01, 1'b0}, // R4 set modem
        {5'b00000, 5'b11111, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1}, // R3 modem 000
        {5'b01000, 5'b11111, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1}, // R2 set tx
        {5'b00000, 5'b11111, 1'b1, 1'b0, 1'b0, 8'hC2, 1'b1}, // R5 fifo 16B, tx
        {5'b00110, 5'b11111, 1'b1, 1'b1, 1'b0, 8'hE2, 1'b1}, // R5 deep, set rx
        {5'b00000, 5'b11111, 1'b1, 1'b1, 1'b1, 8'hE4, 1'b1}, // R7 ready first
        {5'b00000, 5'b11111, 1'b1, 1'b1, 1'b1, 8'hEC, 1'b1}, // R6 timeout next
        {5'b00001, 5'b11111, 1'b1, 1'b1, 1'b0, 8'hE2, 1'b1}, // R6 tx, set line
        {5'b00000, 5'b11111, 1'b1, 1'b1, 1'b1, 8'hE6, 1'b1}, // R2 line wins
        {5'b00000, 5'b11111, 1'b1, 1'b1, 1'b1, 8'hE2, 1'b1}, // R6 tx kept
        {5'b00000, 5'b11111, 1'b1, 1'b1, 1'b1, 8'hE0, 1'b1}, // R6 modem last
        {5'b00000, 5'b11111, 1'b1, 1'b1, 1'b0, 8'hE1, 1'b0}  // R9 all served
    };

    // Compares status and irq against expectations and counts the result.
    task automatic check(input string req, input logic [7:0] exp_st, input logic exp_irq);
        checks++;
        if (status !== exp_st || irq !== exp_irq) begin
            errors++;
            $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                     req, status, irq, exp_st, exp_irq);
        end
    endtask

    // Moves to just after the next falling edge and applies inputs.
    task automatic drive(input logic [4:0] s, input logic [4:0] e, input logic r);
        @(negedge clk);
        src_set = s;
        src_en  = e;
        rd_stb  = r;
        #1;
    endtask

    // Ends a hung run as a failure, still printing the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1", 8'h01, 1'b0);            // held in reset
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {src_set, src_en, fifo_on, fifo_deep, rd_stb} = VEC[i][21:9];
            #1;
            check($sformatf("R%0d vec %0d", (i == 0) ? 1 : 6, i), VEC[i][8:1], VEC[i][0]);
        end

        // R10: set and reported-clear in one cycle keeps the cause
        drive(5'b01000, 5'b11111, 1'b0);
        drive(5'b01000, 5'b11111, 1'b1);
        check("R10 read cycle", 8'hE2, 1'b1);
        drive(5'b00000, 5'b11111, 1'b0);
        check("R10 still pending", 8'hE2, 1'b1);
        drive(5'b00000, 5'b11111, 1'b1);
        drive(5'b00000, 5'b11111, 1'b0);
        check("R6 cleared after read", 8'hE1, 1'b0);

        // R8: set on a disabled cause is ignored
        drive(5'b10000, 5'b01111, 1'b0);
        drive(5'b00000, 5'b01111, 1'b0);
        check("R8 disabled set", 8'hE1, 1'b0);
        drive(5'b00000, 5'b11111, 1'b0);
        check("R8 re-enable shows nothing", 8'hE1, 1'b0);

        // R8: dropping an enable hides and discards a pending cause
        drive(5'b01000, 5'b11111, 1'b0);
        drive(5'b00000, 5'b11111, 1'b0);
        check("R8 tx pending", 8'hE2, 1'b1);
        drive(5'b00000, 5'b10111, 1'b0);
        check("R8 masked at once", 8'hE1, 1'b0);
        drive(5'b00000, 5'b11111, 1'b0);
        check("R8 discarded", 8'hE1, 1'b0);

        // R6: read with nothing pending changes nothing
        drive(5'b00000, 5'b11111, 1'b1);
        check("R6 empty read", 8'hE1, 1'b0);
        drive(5'b00000, 5'b11111, 1'b0);
        check("R6 after empty read", 8'hE1, 1'b0);

        // R7: timeout alone reports its own code
        drive(5'b00100, 5'b11111, 1'b0);
        drive(5'b00000, 5'b11111, 1'b0);
        check("R3 timeout code", 8'hEC, 1'b1);

        // R1: reset while a cause is pending
        drive(5'b00001, 5'b11111, 1'b0);
        drive(5'b00000, 5'b11111, 1'b0);
        check("R2 line over timeout", 8'hE6, 1'b1);
        rst_n = 1'b0;
        fifo_on = 1'b0;
        fifo_deep = 1'b0;
        drive(5'b00000, 5'b11111, 1'b0);
        check("R1 mid-run reset", 8'h01, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule